// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

A GPIO peripheral with a register width of 8, 16, 32 or 64 bits. There is one pin per register bit. Software reaches it over a simple register bus that has a two-bit address, a write strobe and a read strobe. Read data is registered: it appears on the bus after the clock edge that samples the read strobe, and it holds until the next read.

Several choices are fixed when the block is built:

- **Output style.** The output latch is driven either by a plain data register, by a set/clear register pair, or by a single full-word set register that can be read back.
- **Direction register.** There is either a direction register where a 1 means output, a direction register where a 1 means input, or no direction register at all.
- **Register views.** The bus can see a byte-swapped register view, and pin numbering can be bit-reversed.

Pin inputs pass through a two-stage synchroniser before software can read them. Pin outputs and output enables are registers, so each pin can drive a tri-state pad.

Elaboration refuses illegal builds:

- an unsupported width;
- a byte-swapped view at 64 bits;
- both direction-register kinds at once.

Top module: `gpio_ctrl`

## Requirements
- R1: During and after reset, `pin_out` is all 0 and every pin is an input. With an output-high direction register, `pin_oe` is 0 and the direction register reads 0. With an input-high direction register, `pin_oe` is 0 and the direction register reads all 1s.
- R2: In the plain output style, a data-register write loads the whole output latch. Writes to the set and clear addresses have no effect.
- R3: In the set/clear style:
  - a 1 bit written to the set register drives that pin high;
  - a 1 bit written to the clear register drives it low;
  - 0 bits leave pins unchanged;
  - data-register writes are ignored.
- R4: In the single-set style, a set-register write replaces the whole output latch. Reading the set register returns the latch. Data-register writes are ignored.
- R5: With an output-high direction register, a 1 in bit n makes pin n an output (`pin_oe[n]`=1). The register reads back what was written.
- R6: With an input-high direction register, a 1 in bit n makes pin n an input (`pin_oe[n]`=0).
- R7: With no direction register, `pin_oe` is all 1s at all times. Direction writes are ignored and direction reads return 0.
- R8: A data-register read returns `pin_in` after two synchronising flops. A pin level that is stable for three clock edges before the read edge is returned.
- R9: With bit reversal enabled, pin n corresponds to register bit W-1-n in every register.
- R10: With byte swap enabled (16 and 32 bits only), register byte k appears on bus byte (W/8-1-k) for both reads and writes.
- R11: The register map is as follows:

  | Address | Register |
  |---|---|
  | 0 | data |
  | 1 | set |
  | 2 | clear (reads 0) |
  | 3 | direction |

  A read issued in the same cycle as a write to the same address returns the value held before the write. Outputs change only on a write or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe; `bus_rdata` updates at this edge |
| bus_wdata | input | W | Write data (bus view) |
| bus_rdata | output | W | Registered read data (bus view) |
| pin_in | input | W | Pad input levels |
| pin_out | output | W | Output latch, registered |
| pin_oe | output | W | Per-pin output enable, registered |

## Verification
Three builds are driven side by side, each with its own patterns.

- **16-bit set/clear build with an output-high direction register.** Overlapping set and clear masks separate per-bit set and clear from a whole-word load. An all-zero clear shows that 0 bits are ignored. A write and read in the same cycle exposes whether the read sees the pre-write value.
- **32-bit plain build with an input-high direction register and a byte-swapped view.** Asymmetric words such as 0x11223344 tell a byte swap apart from a bit reversal or no transform. A mixed pad pattern, with half the pins driven and half external, shows that reads return pad levels rather than the latch.
- **8-bit single-set build with bit-reversed numbering.** Single-bit and two-bit patterns locate the reversed pin mapping. Successive set writes distinguish replacing the latch from OR-ing into it.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_DIR  = 2'd3
  } reg_sel_e;

  typedef enum int {
    OUT_PLAIN    = 0,
    OUT_SET_CLR  = 1,
    OUT_SET_ONLY = 2
  } out_style_e;

endpackage

// File: rtl/gpio_view.sv
// Maps between pin-indexed words and bus-visible words.
// Bit reversal and byte swap are involutions that commute, so one
// instance serves either direction.
module gpio_view #(
  parameter int W    = 32,
  parameter bit SWAP = 1'b0,
  parameter bit REV  = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;

  logic [W-1:0] rev_w;

  generate
    if (REV) begin : g_rev
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign rev_w[i] = din[W-1-i];
      end
    end else begin : g_norev
      assign rev_w = din;
    end

    if (SWAP) begin : g_swap
      for (genvar b = 0; b < NB; b++) begin : g_byte
        assign dout[b*8 +: 8] = rev_w[(NB-1-b)*8 +: 8];
      end
    end else begin : g_noswap
      assign dout = rev_w;
    end
  endgenerate
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_outlatch.sv
module gpio_outlatch #(
  parameter int                  W     = 32,
  parameter gpio_pkg::out_style_e STYLE = gpio_pkg::OUT_SET_CLR
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_data,
  input  logic         we_set,
  input  logic         we_clr,
  input  logic [W-1:0] wval,
  output logic [W-1:0] q
);
  generate
    if (STYLE == gpio_pkg::OUT_PLAIN) begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (we_data) q <= wval;
      end
    end else if (STYLE == gpio_pkg::OUT_SET_CLR) begin : g_setclr
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (we_set) q <= q | wval;
        else if (we_clr) q <= q & ~wval;
      end
    end else begin : g_setonly
      always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (we_set) q <= wval;
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_dirreg.sv
// Holds the output enables. The register-level view is inverted
// for input-high polarity.
module gpio_dirreg #(
  parameter int W       = 32,
  parameter bit OUT_REG = 1'b1,
  parameter bit IN_REG  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wval,
  output logic [W-1:0] oe,
  output logic [W-1:0] view
);
  generate
    if (OUT_REG) begin : g_outhigh
      always_ff @(posedge clk) begin
        if (rst)     oe <= '0;
        else if (we) oe <= wval;
      end
      assign view = oe;
    end else if (IN_REG) begin : g_inhigh
      always_ff @(posedge clk) begin
        if (rst)     oe <= '0;
        else if (we) oe <= ~wval;
      end
      assign view = ~oe;
    end else begin : g_none
      assign oe   = '1;
      assign view = '0;
    end
  endgenerate
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl #(
  parameter int                  W         = 32,
  parameter gpio_pkg::out_style_e OUT_STYLE = gpio_pkg::OUT_SET_CLR,
  parameter bit                  DIR_OUT   = 1'b1,
  parameter bit                  DIR_IN    = 1'b0,
  parameter bit                  BYTE_SWAP = 1'b0,
  parameter bit                  BIT_REV   = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wen,
  input  logic         bus_ren,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  import gpio_pkg::*;

  localparam bit HAS_SET = (OUT_STYLE != OUT_PLAIN);

  generate
    if (!(W == 8 || W == 16 || W == 32 || W == 64)) begin : g_bad_width
      $error("gpio_ctrl: width must be 8, 16, 32 or 64");
    end
    if (BYTE_SWAP && W == 64) begin : g_bad_swap
      $error("gpio_ctrl: byte-swapped view not allowed at 64 bits");
    end
    if (DIR_OUT && DIR_IN) begin : g_bad_dir
      $error("gpio_ctrl: only one direction register kind may be chosen");
    end
  endgenerate

  reg_sel_e     sel;
  logic [W-1:0] wr_pin;
  logic [W-1:0] sync_q;
  logic [W-1:0] dir_view;
  logic [W-1:0] rd_pin;
  logic [W-1:0] rd_bus;

  assign sel = reg_sel_e'(bus_addr);

  gpio_view #(.W(W), .SWAP(BYTE_SWAP), .REV(BIT_REV)) u_wview (
    .din (bus_wdata),
    .dout(wr_pin)
  );

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_q)
  );

  gpio_outlatch #(.W(W), .STYLE(OUT_STYLE)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .we_data(bus_wen && sel == REG_DATA),
    .we_set (bus_wen && sel == REG_SET),
    .we_clr (bus_wen && sel == REG_CLR),
    .wval   (wr_pin),
    .q      (pin_out)
  );

  gpio_dirreg #(.W(W), .OUT_REG(DIR_OUT), .IN_REG(DIR_IN)) u_dir (
    .clk (clk),
    .rst (rst),
    .we  (bus_wen && sel == REG_DIR),
    .wval(wr_pin),
    .oe  (pin_oe),
    .view(dir_view)
  );

  always_comb begin
    unique case (sel)
      REG_DATA: rd_pin = sync_q;
      REG_SET:  rd_pin = HAS_SET ? pin_out : '0;
      REG_CLR:  rd_pin = '0;
      REG_DIR:  rd_pin = dir_view;
      default:  rd_pin = '0;
    endcase
  end

  gpio_view #(.W(W), .SWAP(BYTE_SWAP), .REV(BIT_REV)) u_rview (
    .din (rd_pin),
    .dout(rd_bus)
  );

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (bus_ren) bus_rdata <= rd_bus;
  end
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int                  W         = 32,
  parameter gpio_pkg::out_style_e OUT_STYLE = gpio_pkg::OUT_SET_CLR,
  parameter bit                  DIR_OUT   = 1'b1,
  parameter bit                  DIR_IN    = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic [1:0]   bus_addr,
  input logic         bus_wen,
  input logic [W-1:0] wr_pin,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe
);
  localparam logic [W-1:0] OE_RST = (DIR_OUT || DIR_IN) ? '0 : '1;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == OE_RST));

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_wen |=> ($stable(pin_out) && $stable(pin_oe)));

  generate
    if (OUT_STYLE == gpio_pkg::OUT_PLAIN) begin : g_plain
      assert_plain_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 2'd0) |=> pin_out == $past(wr_pin));
      assert_plain_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr != 2'd0) |=> $stable(pin_out));
    end else if (OUT_STYLE == gpio_pkg::OUT_SET_CLR) begin : g_setclr
      assert_set_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 2'd1) |=> (pin_out & $past(wr_pin)) == $past(wr_pin));
      assert_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 2'd2) |=> (pin_out & $past(wr_pin)) == '0);
      assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && (bus_addr == 2'd1 || bus_addr == 2'd2))
        |=> (pin_out & ~$past(wr_pin)) == ($past(pin_out) & ~$past(wr_pin)));
    end else begin : g_setonly
      assert_set_only_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 2'd1) |=> pin_out == $past(wr_pin));
    end

    if (DIR_OUT) begin : g_dout
      assert_dir_out_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 2'd3) |=> pin_oe == $past(wr_pin));
    end else if (DIR_IN) begin : g_din
      assert_dir_in_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 2'd3) |=> pin_oe == ~$past(wr_pin));
    end
  endgenerate
endmodule

bind gpio_ctrl gpio_ctrl_chk #(
  .W(W), .OUT_STYLE(OUT_STYLE), .DIR_OUT(DIR_OUT), .DIR_IN(DIR_IN)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
  .wr_pin(wr_pin), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/tb_gpio_ctrl.sv
module tb_gpio_ctrl;
  import gpio_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic        ren = 1'b0;
  logic [31:0] wdata = '0;
  logic        wen_a = 1'b0, wen_b = 1'b0, wen_c = 1'b0;

  always #2 clk = ~clk;

  // Build A: 16-bit set/clear, output-high direction
  logic [15:0] rdata_a, out_a, oe_a, ext_a, pad_a;
  assign pad_a = (out_a & oe_a) | (ext_a & ~oe_a);
  gpio_ctrl #(.W(16), .OUT_STYLE(OUT_SET_CLR), .DIR_OUT(1'b1), .DIR_IN(1'b0),
              .BYTE_SWAP(1'b0), .BIT_REV(1'b0)) dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wen(wen_a), .bus_ren(ren),
    .bus_wdata(wdata[15:0]), .bus_rdata(rdata_a),
    .pin_in(pad_a), .pin_out(out_a), .pin_oe(oe_a));

  // Build B: 32-bit plain, input-high direction, byte swapped
  logic [31:0] rdata_b, out_b, oe_b, ext_b, pad_b;
  assign pad_b = (out_b & oe_b) | (ext_b & ~oe_b);
  gpio_ctrl #(.W(32), .OUT_STYLE(OUT_PLAIN), .DIR_OUT(1'b0), .DIR_IN(1'b1),
              .BYTE_SWAP(1'b1), .BIT_REV(1'b0)) dut_b (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wen(wen_b), .bus_ren(ren),
    .bus_wdata(wdata), .bus_rdata(rdata_b),
    .pin_in(pad_b), .pin_out(out_b), .pin_oe(oe_b));

  // Build C: 8-bit single set, no direction register, bit reversed
  logic [7:0] rdata_c, out_c, oe_c, ext_c, pad_c;
  assign pad_c = (out_c & oe_c) | (ext_c & ~oe_c);
  gpio_ctrl #(.W(8), .OUT_STYLE(OUT_SET_ONLY), .DIR_OUT(1'b0), .DIR_IN(1'b0),
              .BYTE_SWAP(1'b0), .BIT_REV(1'b1)) dut_c (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wen(wen_c), .bus_ren(ren),
    .bus_wdata(wdata[7:0]), .bus_rdata(rdata_c),
    .pin_in(pad_c), .pin_out(out_c), .pin_oe(oe_c));

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_wen(int sel, logic v);
    if (sel == 0) wen_a = v;
    else if (sel == 1) wen_b = v;
    else wen_c = v;
  endtask

  task automatic wr(int sel, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; set_wen(sel, 1'b1);
    @(negedge clk);
    set_wen(sel, 1'b0);
  endtask

  task automatic rd(int sel, logic [1:0] a, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    addr = a; ren = 1'b1;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    ren = 1'b0;
  endtask

  task automatic wr_rd(int sel, logic [1:0] a, logic [31:0] d,
                       logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    addr = a; wdata = d; ren = 1'b1; set_wen(sel, 1'b1);
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    ren = 1'b0; set_wen(sel, 1'b0);
  endtask

  // Monitor: bus_rdata is valid at the negedge after a read edge
  logic ren_seen = 1'b0;
  always @(posedge clk) ren_seen <= ren;

  always @(negedge clk) begin
    if (ren_seen) begin
      if (sb.size() == 0) begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = (it.sel == 0) ? {16'd0, rdata_a} :
              (it.sel == 1) ? rdata_b : {24'd0, rdata_c};
        check(it.tag, act, it.exp);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    ext_a = 16'hA500;
    ext_b = 32'hABCD0000;
    ext_c = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state
    check("R1 A pin_out", {16'd0, out_a}, 32'd0);
    check("R1 A pin_oe", {16'd0, oe_a}, 32'd0);
    check("R1 B pin_oe", oe_b, 32'd0);
    check("R1 B pin_out", out_b, 32'd0);
    check("R1 C pin_out", {24'd0, out_c}, 32'd0);
    check("R7 C pin_oe after reset", {24'd0, oe_c}, 32'h000000FF);
    rd(0, 2'd3, 32'h0000, "R1 A dir reads 0");
    rd(1, 2'd3, 32'hFFFFFFFF, "R1 B input-high dir reads all 1s");

    // Build A: direction and set/clear
    wr(0, 2'd3, 32'h00FF);
    check("R5 A pin_oe", {16'd0, oe_a}, 32'h00FF);
    rd(0, 2'd3, 32'h00FF, "R5 A dir readback");
    wr(0, 2'd1, 32'h0013);
    check("R3 A set", {16'd0, out_a}, 32'h0013);
    wr(0, 2'd1, 32'h0100);
    check("R3 A set keeps others", {16'd0, out_a}, 32'h0113);
    wr(0, 2'd2, 32'h0011);
    check("R3 A clear", {16'd0, out_a}, 32'h0102);
    wr(0, 2'd2, 32'h0000);
    check("R3 A zero clear no effect", {16'd0, out_a}, 32'h0102);
    wr(0, 2'd0, 32'hFFFF);
    check("R3 A data write ignored", {16'd0, out_a}, 32'h0102);
    rd(0, 2'd1, 32'h0102, "R4 A set register readback");
    rd(0, 2'd2, 32'h0000, "R11 A clear reads 0");
    repeat (3) @(negedge clk);
    rd(0, 2'd0, 32'hA502, "R8 A data reads pad state");
    wr_rd(0, 2'd1, 32'h0004, 32'h0102, "R11 A same-cycle read pre-write");
    check("R11 A write after same-cycle read", {16'd0, out_a}, 32'h0106);

    // Build B: input-high direction, plain, byte swap
    wr(1, 2'd3, 32'h0000FFFF);
    check("R6 R10 B pin_oe", oe_b, 32'h0000FFFF);
    rd(1, 2'd3, 32'h0000FFFF, "R6 B dir readback");
    wr(1, 2'd0, 32'h11223344);
    check("R2 R10 B data write swapped", out_b, 32'h44332211);
    wr(1, 2'd1, 32'hFFFFFFFF);
    check("R2 B set write ignored", out_b, 32'h44332211);
    wr(1, 2'd2, 32'hFFFFFFFF);
    check("R2 B clear write ignored", out_b, 32'h44332211);
    repeat (3) @(negedge clk);
    rd(1, 2'd0, 32'h1122CDAB, "R8 R10 B data read swapped pad");

    // Build C: single set, no direction, bit reversed
    wr(2, 2'd1, 32'h01);
    check("R9 C bit0 maps to pin7", {24'd0, out_c}, 32'h80);
    wr(2, 2'd1, 32'h0C);
    check("R4 R9 C set replaces latch", {24'd0, out_c}, 32'h30);
    rd(2, 2'd1, 32'h0C, "R4 C set readback");
    wr(2, 2'd0, 32'hFF);
    check("R4 C data write ignored", {24'd0, out_c}, 32'h30);
    wr(2, 2'd3, 32'h00);
    check("R7 C dir write ignored", {24'd0, oe_c}, 32'hFF);
    rd(2, 2'd3, 32'h00, "R7 C dir reads 0");
    repeat (3) @(negedge clk);
    rd(2, 2'd0, 32'h0C, "R8 R9 C data read reversed");

    repeat (3) @(negedge clk);
    check("scoreboard drained", sb.size(), 32'd0);
    finish_run();
  end
endmodule